// File: doc/BRIEF.md
# Register Field Core

This block is the storage element behind one field of a memory-mapped control or status register. Once per clock it picks the field's next value from whatever software and the surrounding hardware are doing in that cycle. Software reaches it through an access strobe with a write flag, write data and a per-bit enable mask. Hardware reaches it through a data input with enables of either polarity, set and clear inputs, and an event input that feeds interrupt-style capture.

Parameters fix the field's personality at elaboration. They choose the side effect of a read, the effect of a write, single-pulse behaviour, the interrupt capture style, which hardware inputs are present, and whether software or hardware has the last word when both act in the same cycle. Besides the field value, the block gives two one-cycle indications, one for a software read and one for a software action that changed or could change the field. A register decoder and a read multiplexer sit outside the block and use these outputs.

Top module: `reg_field_core`

## Requirements
- R1: While `rst` is high at a rising edge, the field loads `RST_VAL` and the stored previous event input is cleared. The first cycle after reset therefore compares the event input against all zeros.
- R2: `sw_acc` is high exactly when `sw_stb` is high and `sw_wr` is low. `sw_mod` follows the field class. A writable field with no read effect asserts it on writes. A writable field with a read effect asserts it on any strobe. A non-writable field with a read effect asserts it on reads. Any other field holds it low.
- R3: Load write mode: on a write, each bit with `sw_be` = 1 takes `sw_wdata`, and every other bit keeps its value.
- R4: Bitwise write modes act only on bits where `sw_be` = 1. The one-modes act where `sw_wdata` is 1 and the zero-modes act where it is 0. Each mode either sets, clears or inverts the selected bits.
- R5: The whole-field write modes clear or set every bit on any write, whatever the data and mask.
- R6: Read effects clear or set the whole field on a strobe with `sw_wr` low. Writes never trigger them.
- R7: In single-pulse mode a write loads `sw_wdata & sw_be` in place of the write mode. In any cycle with no software or hardware action, the field returns to 0.
- R8: Hardware write loads `hw_data` in one of three ways, chosen by a parameter: always, when `hw_we` is high, or when `hw_we_n` is low. It is unused when an interrupt style is selected.
- R9: Inside the hardware group, `hw_clr` beats `hw_set`, and `hw_set` beats a hardware write or interrupt capture. Each of the first two takes part only if its enable parameter is set.
- R10: With `SW_WINS` = 1, any software action overrides all hardware actions. With `SW_WINS` = 0, any hardware action overrides all software actions.
- R11: Level-sticky capture loads the whole `hw_irq` value when the field is 0 and `hw_irq` is nonzero. Otherwise the field holds.
- R12: Sticky-bit capture ORs `hw_irq` into the field. Sticky edge capture ORs the detected edges into the field. Bits then fall only through software or `hw_clr`.
- R13: Non-sticky edge capture sets the field each cycle to the edge vector. For rise, a bit is 1 where the input is 1 now and was 0 before. For fall, a bit is 1 where the input is 0 now and was 1 before. For any edge, a bit is 1 where the two differ.
- R14: With no software or hardware action, a field that is not in single-pulse mode keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_stb | input | 1 | Software access strobe for this field |
| sw_wr | input | 1 | 1 = write access, 0 = read access |
| sw_wdata | input | WIDTH | Software write data |
| sw_be | input | WIDTH | Per-bit write enable mask |
| hw_data | input | WIDTH | Hardware write data |
| hw_we | input | 1 | Active-high hardware write enable |
| hw_we_n | input | 1 | Active-low hardware write enable |
| hw_set | input | 1 | Hardware set of the whole field |
| hw_clr | input | 1 | Hardware clear of the whole field |
| hw_irq | input | WIDTH | Interrupt event source |
| fld_q | output | WIDTH | Registered field value |
| sw_acc | output | 1 | Software read indication |
| sw_mod | output | 1 | Software modify indication |

## Verification
The hardest cases to reach are the ones where software and hardware act on the field in the same cycle, because only these show the priority order. The situation is harder still when the hardware side carries several actions at once, such as set, clear and an active-low write together. Eight copies of the block with different parameter sets share one stimulus stream, so a single cycle that combines a write or a read with hardware set, clear and enables shows both orderings side by side. The edge-capture copies also need a held event input across a reset to show that the previous-input register was cleared. A scoreboard queues each expected value for the cycle after its stimulus and compares it there.

// File: rtl/fld_cfg_pkg.sv
package fld_cfg_pkg;

  typedef enum logic [1:0] {
    RDFX_NONE,
    RDFX_CLR,
    RDFX_SET
  } rd_fx_e;

  typedef enum logic [3:0] {
    WRFX_NONE,
    WRFX_LOAD,
    WRFX_ONE_SET,
    WRFX_ONE_CLR,
    WRFX_ONE_TGL,
    WRFX_ZERO_SET,
    WRFX_ZERO_CLR,
    WRFX_ZERO_TGL,
    WRFX_ALL_CLR,
    WRFX_ALL_SET
  } wr_fx_e;

  typedef enum logic [1:0] {
    HWWR_NONE,
    HWWR_ALWAYS,
    HWWR_EN_HI,
    HWWR_EN_LO
  } hw_wr_e;

  typedef enum logic [3:0] {
    IRQ_NONE,
    IRQ_LEVEL,
    IRQ_BITS,
    IRQ_RISE_STK,
    IRQ_FALL_STK,
    IRQ_ANY_STK,
    IRQ_RISE_PLS,
    IRQ_FALL_PLS,
    IRQ_ANY_PLS
  } irq_e;

  function automatic bit irq_is_edge(irq_e m);
    return m inside {IRQ_RISE_STK, IRQ_FALL_STK, IRQ_ANY_STK,
                     IRQ_RISE_PLS, IRQ_FALL_PLS, IRQ_ANY_PLS};
  endfunction

  function automatic bit irq_is_sticky(irq_e m);
    return m inside {IRQ_LEVEL, IRQ_BITS, IRQ_RISE_STK, IRQ_FALL_STK, IRQ_ANY_STK};
  endfunction

endpackage

// File: rtl/fld_sw_rules.sv
module fld_sw_rules
  import fld_cfg_pkg::*;
#(
  parameter int     WIDTH = 8,
  parameter rd_fx_e RD_FX = RDFX_NONE,
  parameter wr_fx_e WR_FX = WRFX_LOAD,
  parameter bit     PULSE = 1'b0
) (
  input  logic [WIDTH-1:0] cur_i,
  input  logic             stb_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [WIDTH-1:0] be_i,
  output logic             hit_o,
  output logic [WIDTH-1:0] nxt_o,
  output logic             acc_o,
  output logic             mod_o
);

  localparam bit WRITABLE = PULSE || (WR_FX != WRFX_NONE);
  localparam bit RD_SIDE  = (RD_FX != RDFX_NONE);

  logic             wr_acc;
  logic             rd_acc;
  logic [WIDTH-1:0] ones_sel;
  logic [WIDTH-1:0] zeros_sel;
  logic             wr_hit;
  logic [WIDTH-1:0] wr_val;

  assign wr_acc    = stb_i & wr_i;
  assign rd_acc    = stb_i & ~wr_i;
  assign ones_sel  = wdata_i & be_i;
  assign zeros_sel = ~wdata_i & be_i;

  // Write-side rule selected by WR_FX
  always_comb begin
    wr_hit = 1'b1;
    wr_val = cur_i;
    case (WR_FX)
      WRFX_LOAD:      wr_val = (cur_i & ~be_i) | ones_sel;
      WRFX_ONE_SET:   wr_val = cur_i | ones_sel;
      WRFX_ONE_CLR:   wr_val = cur_i & ~ones_sel;
      WRFX_ONE_TGL:   wr_val = cur_i ^ ones_sel;
      WRFX_ZERO_SET:  wr_val = cur_i | zeros_sel;
      WRFX_ZERO_CLR:  wr_val = cur_i & ~zeros_sel;
      WRFX_ZERO_TGL:  wr_val = cur_i ^ zeros_sel;
      WRFX_ALL_CLR:   wr_val = '0;
      WRFX_ALL_SET:   wr_val = '1;
      default:        wr_hit = 1'b0;
    endcase
  end

  // Software group order: single pulse, write rule, read rule
  always_comb begin
    hit_o = 1'b0;
    nxt_o = cur_i;
    if (PULSE && wr_acc) begin
      hit_o = 1'b1;
      nxt_o = ones_sel;
    end else if (wr_acc && wr_hit) begin
      hit_o = 1'b1;
      nxt_o = wr_val;
    end else if (rd_acc && RD_SIDE) begin
      hit_o = 1'b1;
      nxt_o = (RD_FX == RDFX_SET) ? '1 : '0;
    end
  end

  assign acc_o = rd_acc;

  generate
    if (WRITABLE && !RD_SIDE) begin : g_mod_wr
      assign mod_o = wr_acc;
    end else if (WRITABLE && RD_SIDE) begin : g_mod_any
      assign mod_o = stb_i;
    end else if (RD_SIDE) begin : g_mod_rd
      assign mod_o = rd_acc;
    end else begin : g_mod_none
      assign mod_o = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/fld_edge_det.sv
module fld_edge_det
  import fld_cfg_pkg::*;
#(
  parameter int   WIDTH = 8,
  parameter irq_e MODE  = IRQ_RISE_STK
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] src_i,
  output logic [WIDTH-1:0] ev_o
);

  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= src_i;
  end

  always_comb begin
    case (MODE)
      IRQ_RISE_STK, IRQ_RISE_PLS: ev_o = src_i & ~prev_q;
      IRQ_FALL_STK, IRQ_FALL_PLS: ev_o = ~src_i & prev_q;
      default:                    ev_o = src_i ^ prev_q;
    endcase
  end

endmodule

// File: rtl/fld_hw_rules.sv
module fld_hw_rules
  import fld_cfg_pkg::*;
#(
  parameter int     WIDTH  = 8,
  parameter hw_wr_e HW_WR  = HWWR_EN_HI,
  parameter irq_e   IRQ    = IRQ_NONE,
  parameter bit     SET_EN = 1'b0,
  parameter bit     CLR_EN = 1'b0
) (
  input  logic [WIDTH-1:0] cur_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             we_i,
  input  logic             we_n_i,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [WIDTH-1:0] ev_i,
  output logic             hit_o,
  output logic [WIDTH-1:0] nxt_o
);

  logic             src_hit;
  logic [WIDTH-1:0] src_val;

  // Lowest hardware tier: interrupt capture or hardware write
  always_comb begin
    src_hit = 1'b0;
    src_val = cur_i;
    if (IRQ != IRQ_NONE) begin
      case (IRQ)
        IRQ_LEVEL: begin
          if (cur_i == '0 && ev_i != '0) begin
            src_hit = 1'b1;
            src_val = ev_i;
          end
        end
        IRQ_BITS, IRQ_RISE_STK, IRQ_FALL_STK, IRQ_ANY_STK: begin
          if (ev_i != '0) begin
            src_hit = 1'b1;
            src_val = cur_i | ev_i;
          end
        end
        default: begin
          src_hit = 1'b1;
          src_val = ev_i;
        end
      endcase
    end else begin
      case (HW_WR)
        HWWR_ALWAYS: begin
          src_hit = 1'b1;
          src_val = data_i;
        end
        HWWR_EN_HI: begin
          src_hit = we_i;
          src_val = data_i;
        end
        HWWR_EN_LO: begin
          src_hit = ~we_n_i;
          src_val = data_i;
        end
        default: src_hit = 1'b0;
      endcase
    end
  end

  // Hardware group order: clear, set, then capture/write
  always_comb begin
    if (CLR_EN && clr_i) begin
      hit_o = 1'b1;
      nxt_o = '0;
    end else if (SET_EN && set_i) begin
      hit_o = 1'b1;
      nxt_o = '1;
    end else begin
      hit_o = src_hit;
      nxt_o = src_val;
    end
  end

endmodule

// File: rtl/reg_field_core.sv
module reg_field_core
  import fld_cfg_pkg::*;
#(
  parameter int               WIDTH   = 8,
  parameter logic [WIDTH-1:0] RST_VAL = '0,
  parameter rd_fx_e           RD_FX   = RDFX_NONE,
  parameter wr_fx_e           WR_FX   = WRFX_LOAD,
  parameter bit               PULSE   = 1'b0,
  parameter hw_wr_e           HW_WR   = HWWR_EN_HI,
  parameter irq_e             IRQ     = IRQ_NONE,
  parameter bit               SET_EN  = 1'b0,
  parameter bit               CLR_EN  = 1'b0,
  parameter bit               SW_WINS = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_stb,
  input  logic             sw_wr,
  input  logic [WIDTH-1:0] sw_wdata,
  input  logic [WIDTH-1:0] sw_be,
  input  logic [WIDTH-1:0] hw_data,
  input  logic             hw_we,
  input  logic             hw_we_n,
  input  logic             hw_set,
  input  logic             hw_clr,
  input  logic [WIDTH-1:0] hw_irq,
  output logic [WIDTH-1:0] fld_q,
  output logic             sw_acc,
  output logic             sw_mod
);

  localparam bit STICKY = irq_is_sticky(IRQ);
  localparam bit QUIET_HW = (HW_WR == HWWR_NONE) && (IRQ == IRQ_NONE) && !SET_EN;

  logic             sw_hit;
  logic [WIDTH-1:0] sw_nxt;
  logic             hw_hit;
  logic [WIDTH-1:0] hw_nxt;
  logic [WIDTH-1:0] irq_ev;
  logic [WIDTH-1:0] idle_val;
  logic [WIDTH-1:0] fld_d;

  fld_sw_rules #(
    .WIDTH (WIDTH),
    .RD_FX (RD_FX),
    .WR_FX (WR_FX),
    .PULSE (PULSE)
  ) u_sw (
    .cur_i   (fld_q),
    .stb_i   (sw_stb),
    .wr_i    (sw_wr),
    .wdata_i (sw_wdata),
    .be_i    (sw_be),
    .hit_o   (sw_hit),
    .nxt_o   (sw_nxt),
    .acc_o   (sw_acc),
    .mod_o   (sw_mod)
  );

  generate
    if (irq_is_edge(IRQ)) begin : g_edge
      fld_edge_det #(
        .WIDTH (WIDTH),
        .MODE  (IRQ)
      ) u_edge (
        .clk   (clk),
        .rst   (rst),
        .src_i (hw_irq),
        .ev_o  (irq_ev)
      );
    end else begin : g_level
      assign irq_ev = hw_irq;
    end
  endgenerate

  fld_hw_rules #(
    .WIDTH  (WIDTH),
    .HW_WR  (HW_WR),
    .IRQ    (IRQ),
    .SET_EN (SET_EN),
    .CLR_EN (CLR_EN)
  ) u_hw (
    .cur_i  (fld_q),
    .data_i (hw_data),
    .we_i   (hw_we),
    .we_n_i (hw_we_n),
    .set_i  (hw_set),
    .clr_i  (hw_clr),
    .ev_i   (irq_ev),
    .hit_o  (hw_hit),
    .nxt_o  (hw_nxt)
  );

  assign idle_val = PULSE ? '0 : fld_q;

  // Group arbitration
  always_comb begin
    if (SW_WINS) begin
      if (sw_hit)      fld_d = sw_nxt;
      else if (hw_hit) fld_d = hw_nxt;
      else             fld_d = idle_val;
    end else begin
      if (hw_hit)      fld_d = hw_nxt;
      else if (sw_hit) fld_d = sw_nxt;
      else             fld_d = idle_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) fld_q <= RST_VAL;
    else     fld_q <= fld_d;
  end

  // R1
  rst_value_chk: assert property (@(posedge clk) rst |=> (fld_q == RST_VAL));

  // R9
  hwclr_first_chk: assert property (@(posedge clk) disable iff (rst)
    (!SW_WINS && CLR_EN && hw_clr) |=> (fld_q == '0));

  // R6
  rdclr_chk: assert property (@(posedge clk) disable iff (rst)
    (SW_WINS && RD_FX == RDFX_CLR && sw_stb && !sw_wr) |=> (fld_q == '0));

  // R7
  pulse_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (PULSE && QUIET_HW && !(sw_stb && sw_wr) && !(RD_FX == RDFX_SET && sw_stb))
    |=> (fld_q == '0));

  // R12
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (STICKY && !PULSE && !sw_stb && !(CLR_EN && hw_clr))
    |=> ((fld_q & $past(fld_q)) == $past(fld_q)));

endmodule

// File: tb/reg_field_core_tb_top.sv
module reg_field_core_tb_top;
  import fld_cfg_pkg::*;

  localparam int W = 8;
  localparam int N = 8;

  // Per-copy configurations: A B C D E F G H
  localparam rd_fx_e RDS [N] = '{RDFX_CLR, RDFX_CLR, RDFX_NONE, RDFX_NONE,
                                 RDFX_NONE, RDFX_NONE, RDFX_SET, RDFX_NONE};
  localparam wr_fx_e WRS [N] = '{WRFX_LOAD, WRFX_LOAD, WRFX_ONE_CLR, WRFX_LOAD,
                                 WRFX_NONE, WRFX_ALL_CLR, WRFX_ZERO_TGL, WRFX_ZERO_CLR};
  localparam bit     PLS [N] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam hw_wr_e HWS [N] = '{HWWR_EN_HI, HWWR_EN_HI, HWWR_NONE, HWWR_NONE,
                                 HWWR_NONE, HWWR_NONE, HWWR_EN_LO, HWWR_NONE};
  localparam irq_e   IRQS[N] = '{IRQ_NONE, IRQ_NONE, IRQ_RISE_STK, IRQ_NONE,
                                 IRQ_ANY_PLS, IRQ_LEVEL, IRQ_NONE, IRQ_BITS};
  localparam bit     SETS[N] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam bit     CLRS[N] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam bit     SWW [N] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam logic [W-1:0] RSTV[N] = '{8'h5A, 8'h5A, 8'h00, 8'h00,
                                       8'h00, 8'h00, 8'h0F, 8'h00};

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic         stb = 1'b0, wr = 1'b0, we = 1'b0, wel = 1'b1, hs = 1'b0, hc = 1'b0;
  logic [W-1:0] wd = '0, be = '0, hd = '0, ev = '0;
  logic [N-1:0][W-1:0] qv;
  logic [N-1:0]        accv;
  logic [N-1:0]        modv;

  for (genvar g = 0; g < N; g++) begin : g_dut
    reg_field_core #(
      .WIDTH (W), .RST_VAL (RSTV[g]), .RD_FX (RDS[g]), .WR_FX (WRS[g]),
      .PULSE (PLS[g]), .HW_WR (HWS[g]), .IRQ (IRQS[g]), .SET_EN (SETS[g]),
      .CLR_EN (CLRS[g]), .SW_WINS (SWW[g])
    ) dut_i (
      .clk (clk), .rst (rst), .sw_stb (stb), .sw_wr (wr), .sw_wdata (wd),
      .sw_be (be), .hw_data (hd), .hw_we (we), .hw_we_n (wel), .hw_set (hs),
      .hw_clr (hc), .hw_irq (ev), .fld_q (qv[g]), .sw_acc (accv[g]),
      .sw_mod (modv[g])
    );
  end

  int vecs = 0;
  int errs = 0;
  int cyc  = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  typedef struct {
    int           due;
    int           id;
    logic [W-1:0] val;
    string        req;
  } exp_t;
  exp_t sb[$];

  // Monitor: compares each queued item in its due cycle
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0 && sb[0].due <= cyc) begin
        exp_t e;
        e = sb.pop_front();
        chk($sformatf("%s copy%0d", e.req, e.id), qv[e.id], e.val);
      end
    end
  end

  task automatic drive(input logic s, input logic w, input logic [W-1:0] d,
                       input logic [W-1:0] m, input logic [W-1:0] h,
                       input logic e_we, input logic e_wel, input logic e_set,
                       input logic e_clr, input logic [W-1:0] irq);
    stb = s; wr = w; wd = d; be = m; hd = h;
    we = e_we; wel = e_wel; hs = e_set; hc = e_clr; ev = irq;
  endtask

  task automatic idle(input logic [W-1:0] irq);
    drive(1'b0, 1'b0, '0, '0, '0, 1'b0, 1'b1, 1'b0, 1'b0, irq);
  endtask

  task automatic exp8(input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic [W-1:0] c, input logic [W-1:0] d,
                      input logic [W-1:0] e, input logic [W-1:0] f,
                      input logic [W-1:0] g, input logic [W-1:0] h,
                      input string req);
    logic [W-1:0] vals [N];
    vals = '{a, b, c, d, e, f, g, h};
    for (int k = 0; k < N; k++) sb.push_back('{cyc + 1, k, vals[k], req});
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    idle('0);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int k = 0; k < N; k++) chk($sformatf("R1 copy%0d", k), qv[k], RSTV[k]);
    rst = 1'b0;

    // 1: nothing happens
    idle('0); #1;
    chk("R2 acc idle", {7'b0, accv[0]}, 8'h00);
    chk("R2 mod idle", {7'b0, modv[0]}, 8'h00);
    exp8(8'h5A, 8'h5A, 8'h00, 8'h00, 8'h00, 8'h00, 8'h0F, 8'h00, "R14");
    tick();

    // 2: masked write
    drive(1'b1, 1'b1, 8'h3C, 8'h0F, '0, 1'b0, 1'b1, 1'b0, 1'b0, '0); #1;
    chk("R2 acc on write", {7'b0, accv[0]}, 8'h00);
    chk("R2 mod rw+rd", {7'b0, modv[0]}, 8'h01);
    chk("R2 mod rw", {7'b0, modv[2]}, 8'h01);
    chk("R2 mod ro", {7'b0, modv[4]}, 8'h00);
    exp8(8'h5C, 8'h5C, 8'h00, 8'h0C, 8'h00, 8'h00, 8'h0C, 8'h00, "R3/R4/R5/R7");
    tick();

    // 3: quiet cycle, single pulse drops
    idle('0);
    exp8(8'h5C, 8'h5C, 8'h00, 8'h00, 8'h00, 8'h00, 8'h0C, 8'h00, "R7/R14");
    tick();

    // 4: read
    drive(1'b1, 1'b0, '0, '0, '0, 1'b0, 1'b1, 1'b0, 1'b0, '0); #1;
    chk("R2 acc on read", {7'b0, accv[0]}, 8'h01);
    chk("R2 mod rw+rd read", {7'b0, modv[0]}, 8'h01);
    chk("R2 mod rw read", {7'b0, modv[2]}, 8'h00);
    exp8(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, "R6");
    tick();

    // 5: hw write and first events
    drive(1'b0, 1'b0, '0, '0, 8'h77, 1'b1, 1'b1, 1'b0, 1'b0, 8'h05);
    exp8(8'h77, 8'h77, 8'h05, 8'h00, 8'h05, 8'h05, 8'hFF, 8'h05, "R8/R11/R12/R13");
    tick();

    // 6: event pattern changes
    idle(8'h06);
    exp8(8'h77, 8'h77, 8'h07, 8'h00, 8'h03, 8'h05, 8'hFF, 8'h07, "R11/R12/R13");
    tick();

    // 7: full-mask write, events steady
    drive(1'b1, 1'b1, 8'h01, 8'hFF, '0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h06);
    exp8(8'h01, 8'h01, 8'h06, 8'h01, 8'h00, 8'h00, 8'h01, 8'h01, "R4/R5/R12");
    tick();

    // 8: write against hw set and active-low write
    drive(1'b1, 1'b1, 8'hAA, 8'hFF, 8'h33, 1'b1, 1'b0, 1'b1, 1'b0, 8'h06);
    exp8(8'hAA, 8'hFF, 8'h04, 8'hAA, 8'h00, 8'h00, 8'h54, 8'h00, "R10/R9");
    tick();

    // 9: clear, set and writes together
    drive(1'b0, 1'b0, '0, '0, 8'h33, 1'b1, 1'b0, 1'b1, 1'b1, 8'h06);
    exp8(8'h00, 8'h00, 8'h04, 8'h00, 8'h00, 8'h06, 8'h33, 8'h06, "R9/R8/R11");
    tick();

    // 10: active-high write only
    drive(1'b0, 1'b0, '0, '0, 8'h44, 1'b1, 1'b1, 1'b0, 1'b0, 8'h06);
    exp8(8'h44, 8'h44, 8'h04, 8'h00, 8'h00, 8'h06, 8'h33, 8'h06, "R8");
    tick();

    // 11: read against hw write
    drive(1'b1, 1'b0, '0, '0, 8'h66, 1'b1, 1'b1, 1'b0, 1'b0, 8'h06);
    exp8(8'h00, 8'h66, 8'h04, 8'h00, 8'h00, 8'h06, 8'hFF, 8'h06, "R10/R6");
    tick();

    // 12: upper-half mask write
    drive(1'b1, 1'b1, 8'hFF, 8'hF0, '0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h06);
    exp8(8'hF0, 8'hF6, 8'h04, 8'hF0, 8'h00, 8'h00, 8'hFF, 8'h06, "R3/R4/R5");
    tick();

    // 13: events fall
    idle('0);
    exp8(8'hF0, 8'hF6, 8'h04, 8'h00, 8'h06, 8'h00, 8'hFF, 8'h06, "R13");
    tick();

    // 14: non-sticky returns to 0
    idle('0);
    exp8(8'hF0, 8'hF6, 8'h04, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h06, "R13");
    tick();

    // 15: reset with events held high
    idle(8'h06);
    rst = 1'b1;
    exp8(8'h5A, 8'h5A, 8'h00, 8'h00, 8'h00, 8'h00, 8'h0F, 8'h00, "R1");
    tick();

    // 16: first cycle out of reset sees a cleared previous input
    rst = 1'b0;
    idle(8'h06);
    exp8(8'h5A, 8'h5A, 8'h06, 8'h00, 8'h06, 8'h06, 8'h0F, 8'h06, "R1");
    tick();

    idle('0);
    repeat (2) tick();
    if (sb.size() != 0) begin
      errs++;
      $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      done = 1'b1;
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

endmodule